// File: doc/BRIEF.md
# Four-Flag Status Register

This block keeps the processor's condition flags: carry, zero, negative and equal. Each time the control sequencer signals an arithmetic operation, the block latches the four flag results the arithmetic unit produces. A separate control loads the flags from the 8-bit data bus, which is how a saved status word is restored from the stack. A third control places the stored flags on the data bus so they can be pushed or used as an operand.

The stored flags are always visible on dedicated outputs. The conditional-branch logic reads them there, and the stored carry also feeds the arithmetic unit's carry input. Inside the block, a one-hot selector picks exactly one source for the next flag value: hold, arithmetic result or data bus. If the sequencer asks for both an arithmetic capture and a bus load in the same cycle, the bus load takes precedence and the block raises a conflict indication.

Top module: `flag_status_reg`

## Requirements
- R1: While reset is active, and in the first cycle after it, all four flags read 0, `bus_out` is all zeros and `sel_err` is 0.
- R2: When `alu_op` is 1 and `bus_load` is 0 at a rising clock edge, the flag outputs show `alu_c`, `alu_z`, `alu_n`, `alu_eq` from that edge onward.
- R3: When `bus_load` is 1 at a rising clock edge, the flags take their values from `bus_in`: bit 0 is carry, bit 1 is zero, bit 2 is negative and bit 3 is equal.
- R4: When neither `alu_op` nor `bus_load` is 1 at an edge, all four flags keep their values.
- R5: While `bus_rd` is 1, `bus_out` carries the stored flags at bit 0 (carry), bit 1 (zero), bit 2 (negative) and bit 3 (equal), with every higher bit 0, and `bus_oe` is 1. While `bus_rd` is 0, `bus_out` is all zeros and `bus_oe` is 0.
- R6: When `alu_op` and `bus_load` are both 1 at an edge, the data bus value is stored and the arithmetic flags are discarded.
- R7: With `ERR_REG`=1, `sel_err` is 1 for exactly the cycle after an edge at which `alu_op` and `bus_load` were both 1, and 0 otherwise.
- R8: Bits above bit 3 of `bus_in` have no effect on any flag during a bus load.
- R9: When the flags are read onto the bus in the same cycle as a load, `bus_out` shows the value from before the edge, and the new value appears after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| alu_op | input | 1 | Capture the arithmetic flag results this cycle |
| alu_c | input | 1 | Carry result from the arithmetic unit |
| alu_z | input | 1 | Zero result from the arithmetic unit |
| alu_n | input | 1 | Negative result from the arithmetic unit |
| alu_eq | input | 1 | Equal result from the arithmetic unit |
| bus_load | input | 1 | Load the flags from the data bus this cycle |
| bus_in | input | BUS_W | Data bus value seen by the block |
| bus_rd | input | 1 | Place the stored flags on the data bus |
| bus_out | output | BUS_W | Flag word driven toward the data bus |
| bus_oe | output | 1 | High while the block drives the bus |
| flag_c | output | 1 | Stored carry, also the arithmetic carry input |
| flag_z | output | 1 | Stored zero flag |
| flag_n | output | 1 | Stored negative flag |
| flag_eq | output | 1 | Stored equal flag |
| sel_err | output | 1 | Source conflict indication |

## Verification
The bench builds the block with its defaults: an 8-bit data bus and the registered conflict indication (`ERR_REG`=1). The 8-bit bus lets the bench drive nonzero upper bits during loads and confirm that they are dropped, and that the upper bits read back as zero. The registered conflict output brings the one-cycle delay of `sel_err` within reach, along with the precedence of the bus over the arithmetic unit when both are requested in the same cycle.

// File: rtl/flag_pkg.sv
package flag_pkg;
   // Bit positions of the flags on the data bus.
   localparam int unsigned POS_C  = 0;
   localparam int unsigned POS_Z  = 1;
   localparam int unsigned POS_N  = 2;
   localparam int unsigned POS_EQ = 3;
   localparam int unsigned NFLAGS = 4;

   // Packed so that bit k matches bus bit k.
   typedef struct packed {
      logic eq;
      logic n;
      logic z;
      logic c;
   } flags_t;

   // One-hot source select, one bit per candidate.
   localparam int unsigned SRC_HOLD = 0;
   localparam int unsigned SRC_ALU  = 1;
   localparam int unsigned SRC_BUS  = 2;
   localparam int unsigned NSRC     = 3;
endpackage

// File: rtl/flag_src_sel.sv
module flag_src_sel
   import flag_pkg::*;
(
   input  logic            alu_op,
   input  logic            bus_load,
   output logic [NSRC-1:0] sel,
   output logic            conflict
);
   // The bus load has precedence over the arithmetic capture.
   always_comb begin
      sel = '0;
      if (bus_load)    sel[SRC_BUS]  = 1'b1;
      else if (alu_op) sel[SRC_ALU]  = 1'b1;
      else             sel[SRC_HOLD] = 1'b1;
   end

   assign conflict = alu_op & bus_load;
endmodule

// File: rtl/flag_store.sv
module flag_store
   import flag_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] sel,
   input  flags_t          alu_flags,
   input  flags_t          bus_flags,
   output flags_t          flags_q
);
   flags_t next_flags;

   // AND-OR merge: only the selected candidate reaches the register.
   always_comb begin
      next_flags = ({NFLAGS{sel[SRC_HOLD]}} & flags_q)
                 | ({NFLAGS{sel[SRC_ALU]}}  & alu_flags)
                 | ({NFLAGS{sel[SRC_BUS]}}  & bus_flags);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) flags_q <= '0;
      else        flags_q <= next_flags;
   end
endmodule

// File: rtl/flag_bus_drv.sv
module flag_bus_drv
   import flag_pkg::*;
#(
   parameter int unsigned BUS_W = 8
) (
   input  flags_t           flags_q,
   input  logic             bus_rd,
   output logic [BUS_W-1:0] bus_out,
   output logic             bus_oe
);
   for (genvar i = 0; i < BUS_W; i++) begin : g_bit
      if (i < NFLAGS) begin : g_flag
         assign bus_out[i] = bus_rd & flags_q[i];
      end else begin : g_pad
         assign bus_out[i] = 1'b0;
      end
   end

   assign bus_oe = bus_rd;
endmodule

// File: rtl/flag_status_reg.sv
module flag_status_reg
   import flag_pkg::*;
#(
   parameter int unsigned BUS_W   = 8,
   parameter bit          ERR_REG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             alu_op,
   input  logic             alu_c,
   input  logic             alu_z,
   input  logic             alu_n,
   input  logic             alu_eq,
   input  logic             bus_load,
   input  logic [BUS_W-1:0] bus_in,
   input  logic             bus_rd,
   output logic [BUS_W-1:0] bus_out,
   output logic             bus_oe,
   output logic             flag_c,
   output logic             flag_z,
   output logic             flag_n,
   output logic             flag_eq,
   output logic             sel_err
);
   if (BUS_W < NFLAGS) begin : g_bad_width
      $error("flag_status_reg: BUS_W must be at least 4");
   end

   flags_t          alu_flags;
   flags_t          bus_flags;
   flags_t          flags_q;
   logic [NSRC-1:0] src_sel;
   logic            conflict;

   assign alu_flags = '{eq: alu_eq, n: alu_n, z: alu_z, c: alu_c};
   assign bus_flags = flags_t'(bus_in[NFLAGS-1:0]);

   flag_src_sel u_sel (
      .alu_op   (alu_op),
      .bus_load (bus_load),
      .sel      (src_sel),
      .conflict (conflict)
   );

   flag_store u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .sel       (src_sel),
      .alu_flags (alu_flags),
      .bus_flags (bus_flags),
      .flags_q   (flags_q)
   );

   flag_bus_drv #(.BUS_W(BUS_W)) u_drv (
      .flags_q (flags_q),
      .bus_rd  (bus_rd),
      .bus_out (bus_out),
      .bus_oe  (bus_oe)
   );

   assign flag_c  = flags_q.c;
   assign flag_z  = flags_q.z;
   assign flag_n  = flags_q.n;
   assign flag_eq = flags_q.eq;

   if (ERR_REG) begin : g_err_reg
      logic err_q;
      always_ff @(posedge clk) begin
         if (!rst_n) err_q <= 1'b0;
         else        err_q <= conflict;
      end
      assign sel_err = err_q;
   end else begin : g_err_comb
      assign sel_err = conflict;
   end
endmodule

// File: rtl/flag_status_chk.sv
module flag_status_chk #(
   parameter int unsigned BUS_W   = 8,
   parameter bit          ERR_REG = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             alu_op,
   input logic             alu_c,
   input logic             alu_z,
   input logic             alu_n,
   input logic             alu_eq,
   input logic             bus_load,
   input logic [BUS_W-1:0] bus_in,
   input logic             bus_rd,
   input logic [BUS_W-1:0] bus_out,
   input logic             bus_oe,
   input logic [3:0]       flag_vec,
   input logic [2:0]       src_sel,
   input logic             sel_err
);
   // R2
   alu_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (alu_op && !bus_load) |=> (flag_vec == $past({alu_eq, alu_n, alu_z, alu_c})));

   // R3 R6 R8
   bus_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_load |=> (flag_vec == $past(bus_in[3:0])));

   // R4
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!alu_op && !bus_load) |=> $stable(flag_vec));

   // R5
   idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |-> (bus_out == '0 && !bus_oe));

   // R6 single internal source
   one_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(src_sel) == 1);

   if (ERR_REG) begin : g_err_chk
      // R7
      err_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (alu_op && bus_load) |=> sel_err);
      // R7
      err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !(alu_op && bus_load) |=> !sel_err);
   end
endmodule

bind flag_status_reg flag_status_chk #(.BUS_W(BUS_W), .ERR_REG(ERR_REG)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .alu_op   (alu_op),
   .alu_c    (alu_c),
   .alu_z    (alu_z),
   .alu_n    (alu_n),
   .alu_eq   (alu_eq),
   .bus_load (bus_load),
   .bus_in   (bus_in),
   .bus_rd   (bus_rd),
   .bus_out  (bus_out),
   .bus_oe   (bus_oe),
   .flag_vec ({flag_eq, flag_n, flag_z, flag_c}),
   .src_sel  (src_sel),
   .sel_err  (sel_err)
);

// File: tb/test_flag_status_reg.sv
module test_flag_status_reg;
   localparam int unsigned BUS_W = 8;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             alu_op = 1'b0;
   logic             alu_c = 1'b0, alu_z = 1'b0, alu_n = 1'b0, alu_eq = 1'b0;
   logic             bus_load = 1'b0;
   logic [BUS_W-1:0] bus_in = '0;
   logic             bus_rd = 1'b0;
   logic [BUS_W-1:0] bus_out;
   logic             bus_oe;
   logic             flag_c, flag_z, flag_n, flag_eq;
   logic             sel_err;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   typedef struct {
      logic [3:0] f;
      logic       err;
      string      tag;
   } exp_t;

   exp_t       exp_q[$];
   logic [3:0] model_f = 4'h0;

   always #10 clk = ~clk;

   flag_status_reg #(.BUS_W(BUS_W), .ERR_REG(1'b1)) i_flag_status_reg (
      .clk(clk), .rst_n(rst_n), .alu_op(alu_op), .alu_c(alu_c), .alu_z(alu_z),
      .alu_n(alu_n), .alu_eq(alu_eq), .bus_load(bus_load), .bus_in(bus_in),
      .bus_rd(bus_rd), .bus_out(bus_out), .bus_oe(bus_oe), .flag_c(flag_c),
      .flag_z(flag_z), .flag_n(flag_n), .flag_eq(flag_eq), .sel_err(sel_err)
   );

   task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, expv);
      end
   endtask

   // Monitor: compare registered outputs against the scoreboard.
   always @(negedge clk) begin
      if (exp_q.size() > 0) begin
         exp_t e;
         e = exp_q.pop_front();
         check({flag_eq, flag_n, flag_z, flag_c} == e.f, {e.tag, " flags"},
               {12'h0, flag_eq, flag_n, flag_z, flag_c}, {12'h0, e.f});
         check(sel_err == e.err, {e.tag, " sel_err"}, {15'h0, sel_err}, {15'h0, e.err});
      end
   end

   // Driver: one cycle of stimulus, bus readback checked before the edge.
   task automatic step(input logic a_op, input logic [3:0] a_f, input logic ld,
                       input logic [BUS_W-1:0] din, input logic rd, input string tag);
      exp_t e;
      @(negedge clk);
      alu_op = a_op;
      {alu_eq, alu_n, alu_z, alu_c} = a_f;
      bus_load = ld;
      bus_in = din;
      bus_rd = rd;
      #1;
      if (rd) begin
         // R5 R9: pre-edge value, flags in bits 3..0, upper bits zero
         check(bus_out == {4'h0, model_f} && bus_oe, {tag, " R5 read"},
               {7'h0, bus_oe, bus_out}, {7'h0, 1'b1, 4'h0, model_f});
      end else begin
         // R5: idle bus
         check(bus_out == '0 && !bus_oe, {tag, " R5 idle"},
               {7'h0, bus_oe, bus_out}, 16'h0);
      end
      if (ld)         model_f = din[3:0];
      else if (a_op)  model_f = a_f;
      e.f = model_f;
      e.err = a_op & ld;
      e.tag = tag;
      @(posedge clk);
      exp_q.push_back(e);
   endtask

   task automatic report();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: state during reset
      check({flag_eq, flag_n, flag_z, flag_c} == 4'h0 && bus_out == '0 && !sel_err,
            "R1 in reset", {7'h0, sel_err, bus_out}, 16'h0);
      rst_n = 1'b1;
      @(posedge clk);
      @(negedge clk);
      // R1: first cycle after reset
      check({flag_eq, flag_n, flag_z, flag_c} == 4'h0 && !sel_err,
            "R1 after reset", {11'h0, sel_err, flag_eq, flag_n, flag_z, flag_c}, 16'h0);

      step(1'b1, 4'b0101, 1'b0, 8'h00, 1'b0, "R2 capture 0101");
      step(1'b0, 4'b1010, 1'b0, 8'h0F, 1'b0, "R4 hold");
      step(1'b0, 4'b0000, 1'b0, 8'h00, 1'b1, "R5 readback");
      step(1'b0, 4'b0000, 1'b1, 8'hFA, 1'b0, "R3 R8 load FA");
      step(1'b0, 4'b0000, 1'b0, 8'h00, 1'b1, "R5 readback after load");
      step(1'b1, 4'b0011, 1'b1, 8'h06, 1'b0, "R6 R7 conflict");
      step(1'b0, 4'b0000, 1'b0, 8'h00, 1'b0, "R7 error clears");
      step(1'b0, 4'b0000, 1'b1, 8'h39, 1'b1, "R9 read during load");
      step(1'b0, 4'b0000, 1'b0, 8'h00, 1'b1, "R9 new value visible");
      step(1'b0, 4'b0000, 1'b1, 8'hF0, 1'b0, "R8 upper bits only");
      for (int k = 0; k < 16; k++) begin
         step(1'b1, 4'(k * 7 + 3), 1'b0, 8'hC5, (k % 3) == 0, "R2 pattern sweep");
      end
      for (int k = 0; k < 4; k++) begin
         step(1'b0, 4'h0, 1'b1, 8'(1 << k), 1'b1, "R3 single bit position");
      end
      step(1'b0, 4'h0, 1'b0, 8'h00, 1'b0, "R4 final hold");
      @(negedge clk);
      @(negedge clk);
      done = 1'b1;
      report();
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=running expected=finished");
         report();
      end
   end
endmodule